// File: doc/BRIEF.md
# Hysteretic frequency lock detector

The detector decides whether a fast oscillator clock is running at the intended integer multiple of a slower reference clock. It counts oscillator cycles over a window made of a fixed number of reference cycles, compares that count with the expected count, converts the difference into a magnitude in parts per million, and drives one lock flag. Only frequency is judged; the relative phase of the two clocks plays no part.

The flag has hysteresis. It rises only when a window measures below a tight threshold (300 ppm by default). It falls only when a window measures above a wide threshold (1000 ppm by default). Any result in between leaves it where it was, so an oscillator that wanders near one boundary does not make the flag chatter. Three asynchronous clock domains are involved: reference, oscillator and sample. Counts cross into the sample domain through a toggle handshake over a register that holds its value for a whole window. Both outputs are plain status levels in the sample domain. They carry no valid/ready pair and accept no back-pressure. Each level holds until the next complete window replaces it.

Top module: `freq_lock_detect`

## Requirements
- R1: While reset is asserted and after its release, `locked` is 0 and `offset_ppm` is 0 until a measured result is available.
- R2: A window spans `WINDOW_REFS` reference cycles. A window whose oscillator count equals `EXPECTED_OSC` reports 0 ppm.
- R3: For a count N, the reported value is floor(|N - EXPECTED_OSC| * 1000000 / EXPECTED_OSC). The difference is clamped to `EXPECTED_OSC`, and the result saturates at the all-ones value of `offset_ppm`.
- R4: A result strictly below `SET_PPM` drives `locked` to 1.
- R5: A result strictly above `CLR_PPM` drives `locked` to 0.
- R6: A result from `SET_PPM` to `CLR_PPM` inclusive leaves `locked` unchanged. Consequently the flag is never raised by a result in that band, including during acquisition.
- R7: The first window after reset is discarded. The first published result comes from the second complete window.
- R8: `offset_ppm` and `locked` change at most once per window and are stable between results.
- R9: The oscillator counter has at least twice the expected count of headroom. Offsets well beyond the 1000 ppm pull-in range are therefore measured without wrap.
- R10: Oscillators that run slow and oscillators that run fast by the same count report the same magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset, synchronized into each domain |
| ref_clk | input | 1 | Reference clock that defines the window |
| osc_clk | input | 1 | Oscillator clock being measured |
| smp_clk | input | 1 | Clock of the measurement and output domain |
| locked | output | 1 | Lock flag with hysteresis |
| offset_ppm | output | PPM_W | Magnitude of the latest window's frequency offset in ppm |

## Verification
The assertions assume three things about the inputs. A new window result never arrives while the divider is still busy. The oscillator counter never reaches its ceiling. The sample clock is fast enough to finish capture and division well inside one window. The bench drives the reference and the oscillator as phase-locked clocks, so the synchronizer latency is identical for every window. It adds or removes oscillator pulses only in the middle of a window, never near its edges, and uses offsets of at most a few dozen counts. The 100 MHz sample clock finishes each result within a small fraction of a window.

// File: rtl/fld_pkg.sv
`timescale 1ns/1ps
package fld_pkg;
  localparam int unsigned PPM_SCALE   = 1_000_000;
  localparam int unsigned PPM_SCALE_W = 20;   // bits to hold PPM_SCALE

  typedef enum logic [1:0] {
    VERDICT_SET   = 2'd0,
    VERDICT_CLEAR = 2'd1,
    VERDICT_KEEP  = 2'd2
  } lock_verdict_e;

  // Hysteresis rule: below set limit raises, above clear limit drops.
  function automatic lock_verdict_e judge(input logic [31:0] ppm,
                                          input logic [31:0] set_lim,
                                          input logic [31:0] clr_lim);
    if (ppm < set_lim)      return VERDICT_SET;
    else if (ppm > clr_lim) return VERDICT_CLEAR;
    else                    return VERDICT_KEEP;
  endfunction
endpackage

// File: rtl/fld_rst_sync.sv
`timescale 1ns/1ps
module fld_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain[STAGES-1];
endmodule

// File: rtl/fld_ref_window.sv
`timescale 1ns/1ps
module fld_ref_window #(
  parameter int WINDOW_REFS = 16384
) (
  input  logic ref_clk,
  input  logic r_rst_n,
  output logic tick_tgl
);
  localparam int WIN_W = (WINDOW_REFS > 1) ? $clog2(WINDOW_REFS) : 1;
  localparam logic [WIN_W-1:0] LAST = WIN_W'(WINDOW_REFS - 1);

  logic [WIN_W-1:0] ref_cnt;

  always_ff @(posedge ref_clk or negedge r_rst_n) begin
    if (!r_rst_n) begin
      ref_cnt  <= '0;
      tick_tgl <= 1'b0;
    end else if (ref_cnt == LAST) begin
      ref_cnt  <= '0;
      tick_tgl <= ~tick_tgl;
    end else begin
      ref_cnt  <= ref_cnt + 1'b1;
    end
  end

  // R2: a window never runs past its configured length
  assert_window_len_R2: assert property (@(posedge ref_clk) disable iff (!r_rst_n)
    (ref_cnt == LAST) |=> (ref_cnt == '0));
endmodule

// File: rtl/fld_osc_counter.sv
`timescale 1ns/1ps
module fld_osc_counter #(
  parameter int CNT_W       = 21,
  parameter int SYNC_STAGES = 2
) (
  input  logic             osc_clk,
  input  logic             o_rst_n,
  input  logic             tick_tgl,
  output logic [CNT_W-1:0] cnt_hold,
  output logic             pub_tgl
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [SYNC_STAGES-1:0] tk_sync;
  logic                   tk_seen;
  logic                   primed;
  logic [CNT_W-1:0]       run_cnt;
  logic                   tick_evt;
  logic [CNT_W-1:0]       cnt_inc;

  assign tick_evt = tk_sync[SYNC_STAGES-1] ^ tk_seen;
  assign cnt_inc  = (run_cnt == CNT_MAX) ? CNT_MAX : run_cnt + 1'b1;

  always_ff @(posedge osc_clk or negedge o_rst_n) begin
    if (!o_rst_n) begin
      tk_sync  <= '0;
      tk_seen  <= 1'b0;
      primed   <= 1'b0;
      run_cnt  <= '0;
      cnt_hold <= '0;
      pub_tgl  <= 1'b0;
    end else begin
      tk_sync <= {tk_sync[SYNC_STAGES-2:0], tick_tgl};
      tk_seen <= tk_sync[SYNC_STAGES-1];
      if (tick_evt) begin
        run_cnt <= '0;
        primed  <= 1'b1;
        if (primed) begin          // R7: only a fully bounded window is published
          cnt_hold <= cnt_inc;
          pub_tgl  <= ~pub_tgl;
        end
      end else begin
        run_cnt <= cnt_inc;
      end
    end
  end

  // R9: headroom is never exhausted by the oscillator count
  assert_no_overflow_R9: assert property (@(posedge osc_clk) disable iff (!o_rst_n)
    run_cnt != CNT_MAX);

  // R8: the held count only moves together with a publication toggle
  assert_hold_with_toggle_R8: assert property (@(posedge osc_clk) disable iff (!o_rst_n)
    !$stable(cnt_hold) |-> !$stable(pub_tgl));
endmodule

// File: rtl/fld_ppm_divider.sv
`timescale 1ns/1ps
module fld_ppm_divider #(
  parameter int NUM_W = 41,
  parameter int DEN   = 524288
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] numer,
  output logic             done,
  output logic [NUM_W-1:0] quot
);
  localparam int R_W  = $clog2(DEN) + 1;
  localparam int IT_W = $clog2(NUM_W + 1);
  localparam logic [R_W:0]    DEN_X = (R_W+1)'(DEN);
  localparam logic [IT_W-1:0] LAST  = IT_W'(NUM_W - 1);

  logic             busy;
  logic [IT_W-1:0]  iter;
  logic [R_W-1:0]   rem;
  logic [NUM_W-1:0] shreg;
  logic [R_W:0]     trial;
  logic             ge;
  logic [R_W-1:0]   rem_nx;

  // one restoring step per cycle; quotient bits enter shreg from the right
  assign trial  = {rem, shreg[NUM_W-1]};
  assign ge     = (trial >= DEN_X);
  assign rem_nx = ge ? R_W'(trial - DEN_X) : R_W'(trial);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      iter  <= '0;
      rem   <= '0;
      shreg <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy  <= 1'b1;
        iter  <= '0;
        rem   <= '0;
        shreg <= numer;
      end else if (busy) begin
        shreg <= {shreg[NUM_W-2:0], ge};
        rem   <= rem_nx;
        iter  <= iter + 1'b1;
        if (iter == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = shreg;

  // R3: a new window result must not arrive while a division is running
  assert_start_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/freq_lock_detect.sv
`timescale 1ns/1ps
module freq_lock_detect #(
  parameter int WINDOW_REFS  = 16384,
  parameter int EXPECTED_OSC = 524288,
  parameter int SET_PPM      = 300,
  parameter int CLR_PPM      = 1000,
  parameter int PPM_W        = 20,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             rst_n,
  input  logic             ref_clk,
  input  logic             osc_clk,
  input  logic             smp_clk,
  output logic             locked,
  output logic [PPM_W-1:0] offset_ppm
);
  import fld_pkg::*;

  localparam int CNT_W = $clog2(EXPECTED_OSC) + 2;          // R9 headroom
  localparam int NUM_W = CNT_W + int'(PPM_SCALE_W);
  localparam logic [CNT_W-1:0] EXP_C   = CNT_W'(EXPECTED_OSC);
  localparam logic [NUM_W-1:0] MEGA    = NUM_W'(PPM_SCALE);
  localparam logic [NUM_W-1:0] PPM_TOP = NUM_W'({PPM_W{1'b1}});
  localparam logic [PPM_W-1:0] SET_P   = PPM_W'(SET_PPM);
  localparam logic [PPM_W-1:0] CLR_P   = PPM_W'(CLR_PPM);

  logic r_rst_n, o_rst_n, s_rst_n;

  fld_rst_sync #(.STAGES(SYNC_STAGES)) u_rs_ref (.clk(ref_clk), .arst_n(rst_n), .srst_n(r_rst_n));
  fld_rst_sync #(.STAGES(SYNC_STAGES)) u_rs_osc (.clk(osc_clk), .arst_n(rst_n), .srst_n(o_rst_n));
  fld_rst_sync #(.STAGES(SYNC_STAGES)) u_rs_smp (.clk(smp_clk), .arst_n(rst_n), .srst_n(s_rst_n));

  logic             tick_tgl;
  logic [CNT_W-1:0] cnt_hold;
  logic             pub_tgl;

  fld_ref_window #(.WINDOW_REFS(WINDOW_REFS)) u_win (
    .ref_clk(ref_clk), .r_rst_n(r_rst_n), .tick_tgl(tick_tgl));

  fld_osc_counter #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_cnt (
    .osc_clk(osc_clk), .o_rst_n(o_rst_n), .tick_tgl(tick_tgl),
    .cnt_hold(cnt_hold), .pub_tgl(pub_tgl));

  // ---- sample domain: handshake capture of the held count ----
  logic [SYNC_STAGES-1:0] pub_sync;
  logic                   pub_seen;
  logic                   pub_evt;
  logic                   cap_vld;
  logic [CNT_W-1:0]       cnt_cap;
  logic [CNT_W-1:0]       err_raw;
  logic [CNT_W-1:0]       err_clamped;
  logic [NUM_W-1:0]       numer;
  logic                   div_done;
  logic [NUM_W-1:0]       quot;
  logic [PPM_W-1:0]       ppm_sat;

  assign pub_evt = pub_sync[SYNC_STAGES-1] ^ pub_seen;

  always_ff @(posedge smp_clk or negedge s_rst_n) begin
    if (!s_rst_n) begin
      pub_sync <= '0;
      pub_seen <= 1'b0;
      cap_vld  <= 1'b0;
      cnt_cap  <= '0;
    end else begin
      pub_sync <= {pub_sync[SYNC_STAGES-2:0], pub_tgl};
      pub_seen <= pub_sync[SYNC_STAGES-1];
      cap_vld  <= pub_evt;
      if (pub_evt) cnt_cap <= cnt_hold;   // held stable for a whole window
    end
  end

  // magnitude of the count error, symmetric in sign (R10), clamped (R3)
  assign err_raw     = (cnt_cap >= EXP_C) ? (cnt_cap - EXP_C) : (EXP_C - cnt_cap);
  assign err_clamped = (err_raw > EXP_C) ? EXP_C : err_raw;
  assign numer       = NUM_W'(err_clamped) * MEGA;

  fld_ppm_divider #(.NUM_W(NUM_W), .DEN(EXPECTED_OSC)) u_div (
    .clk(smp_clk), .rst_n(s_rst_n), .start(cap_vld), .numer(numer),
    .done(div_done), .quot(quot));

  assign ppm_sat = (quot > PPM_TOP) ? {PPM_W{1'b1}} : PPM_W'(quot);

  always_ff @(posedge smp_clk or negedge s_rst_n) begin
    if (!s_rst_n) begin
      offset_ppm <= '0;
      locked     <= 1'b0;
    end else if (div_done) begin
      offset_ppm <= ppm_sat;
      unique case (judge(32'(ppm_sat), 32'(SET_PPM), 32'(CLR_PPM)))
        VERDICT_SET:   locked <= 1'b1;
        VERDICT_CLEAR: locked <= 1'b0;
        default:       locked <= locked;
      endcase
    end
  end

  // R4: the flag rises only on a result under the set limit
  assert_lock_rise_R4: assert property (@(posedge smp_clk) disable iff (!s_rst_n)
    $rose(locked) |-> (offset_ppm < SET_P));

  // R5: the flag falls only on a result over the clear limit
  assert_lock_fall_R5: assert property (@(posedge smp_clk) disable iff (!s_rst_n)
    $fell(locked) |-> (offset_ppm > CLR_P));

  // R6: a new result inside the band leaves the flag alone
  assert_band_hold_R6: assert property (@(posedge smp_clk) disable iff (!s_rst_n)
    (!$stable(offset_ppm) && offset_ppm >= SET_P && offset_ppm <= CLR_P) |-> $stable(locked));
endmodule

// File: tb/freq_lock_detect_test.sv
`timescale 1ns/1ps
module freq_lock_detect_test;
  localparam int WIN  = 256;
  localparam int MULT = 8;
  localparam int EXP  = WIN * MULT;
  localparam int NWIN = 24;

  logic        rst_n   = 1'b0;
  logic        ref_clk = 1'b0;
  logic        osc_clk = 1'b0;
  logic        smp_clk = 1'b0;
  logic        locked;
  logic [19:0] offset_ppm;

  freq_lock_detect #(
    .WINDOW_REFS(WIN), .EXPECTED_OSC(EXP), .SET_PPM(300), .CLR_PPM(1000),
    .PPM_W(20), .SYNC_STAGES(2)
  ) uut (
    .rst_n(rst_n), .ref_clk(ref_clk), .osc_clk(osc_clk), .smp_clk(smp_clk),
    .locked(locked), .offset_ppm(offset_ppm));

  always #5 smp_clk = ~smp_clk;

  int    checks = 0;
  int    failures = 0;
  logic  finished = 1'b0;
  logic  want_check = 1'b0;
  logic  late_probe = 1'b0;
  int    exp_ppm = 0;
  logic  exp_lock = 1'b0;
  string tag_ofs = "R7";
  string tag_lock = "R7";

  task automatic check_val(input string tag, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // samples away from the active edge of the output domain
  always @(negedge smp_clk) begin
    if (want_check) begin
      want_check = 1'b0;
      check_val(late_probe ? "R8" : tag_ofs, "offset_ppm", int'(offset_ppm), exp_ppm);
      check_val(late_probe ? "R8" : tag_lock, "locked", int'(locked), int'(exp_lock));
    end
  end

  task automatic osc_pulses(input int n);
    repeat (n) begin
      #1 osc_clk = 1'b1;
      #1 osc_clk = 1'b0;
    end
  endtask

  // one reference cycle: ref rises 1 ns ahead of an oscillator edge
  task automatic ref_cycle(input int low_pulses);
    ref_clk = 1'b1;
    osc_pulses(MULT/2);
    ref_clk = 1'b0;
    osc_pulses(low_pulses);
  endtask

  // k extra (or missing) oscillator cycles, all placed mid-window
  task automatic run_window(input int k);
    for (int c = 0; c < WIN; c++) begin
      int np;
      np = MULT/2;
      if (k > 0 && c == 100) np = np + k;
      if (k < 0 && c >= 100 && c < 100 - k) np = np - 1;
      ref_cycle(np);
      if (c == 150) begin late_probe = 1'b0; want_check = 1'b1; end
      if (c == 230) begin late_probe = 1'b1; want_check = 1'b1; end
    end
  endtask

  function automatic int ppm_of(input int k);
    longint a;
    a = (k < 0) ? -k : k;
    if (a > EXP) a = EXP;
    return int'((a * 1000000) / EXP);
  endfunction

  int ks [NWIN] = '{1, 2, 0, 1, 2, -2, 3, -1, -2, 0, -3, 0,
                    25, -25, 0, -1, 1, 4, -4, 0, 5, 2, -6, 0};

  initial begin
    for (int c = 0; c < 20; c++) ref_cycle(MULT/2);
    @(negedge smp_clk);
    check_val("R1", "offset_ppm in reset", int'(offset_ppm), 0);
    check_val("R1", "locked in reset", int'(locked), 0);
    rst_n = 1'b1;
    // window 0 carries a large offset; it must be discarded (R7)
    exp_ppm = 0; exp_lock = 1'b0; tag_ofs = "R1"; tag_lock = "R1";
    run_window(7);
    tag_ofs = "R7"; tag_lock = "R7";
    for (int i = 0; i < NWIN; i++) begin
      int p;
      run_window(ks[i]);          // checks the result of the window before
      p = ppm_of(ks[i]);
      exp_ppm = p;
      if (p < 300)       begin exp_lock = 1'b1; tag_lock = "R4"; end
      else if (p > 1000) begin exp_lock = 1'b0; tag_lock = "R5"; end
      else               tag_lock = "R6";
      if (ks[i] == 0)                        tag_ofs = "R2";
      else if (ks[i] >= 20 || ks[i] <= -20)  tag_ofs = "R9";
      else if (ks[i] < 0)                    tag_ofs = "R10";
      else                                   tag_ofs = "R3";
    end
    run_window(0);
    #50;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule